// File: doc/BRIEF.md
# Converter power mode controller

This block sets the operating power state of a data converter. Two configuration bits arrive as plain inputs. One is the low-power select, which is bit 16 of the converter's configuration word. The other is the power-save select, which is bit 4 of that word. A command strobe carries a command bit and a power-save/resume bit.

The block drives the following outputs:
- enables for the bias generator, the oscillator, the analog section and the digital filter;
- a 2-bit code that reports the current mode;
- a ready flag that is high while the converter can run conversions.

There are two power-save states, and the power-save select picks between them. Standby keeps the oscillator and bias running, so the converter can resume at once. Sleep turns everything off. On resume from sleep the block waits through a counted oscillator start-up period before operation continues.

There are five states:
- `ST_NORMAL`: active at full power.
- `ST_LOWPWR`: active at reduced power.
- `ST_STANDBY`: shallow save.
- `ST_SLEEP`: deep save.
- `ST_WAKE`: oscillator start-up after sleep.

The transitions are:
- *mode follow*: `ST_NORMAL` and `ST_LOWPWR` move between each other as the low-power select changes.
- *save-shallow*: active to `ST_STANDBY`.
- *save-deep*: active to `ST_SLEEP`.
- *standby resume*: `ST_STANDBY` to active.
- *sleep resume*: `ST_SLEEP` to `ST_WAKE`.
- *wake done*: `ST_WAKE` to active once `WAKE_CYCLES` cycles have passed.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the block is in normal mode. The mode code is 00, ready is 1, and the bias, oscillator, analog and filter enables are all 1.
- R2: In an active mode, the block is in low power (code 01) on the clock after `cfg_lp_sel` is 1, and in normal (code 00) on the clock after it is 0. All four enables stay 1 and ready stays 1.
- R3: A save command (`cmd_valid`=1, `cmd_cb`=1, `cmd_psr`=1) taken in an active mode moves the block on the next clock. It goes to standby (code 10) if `cfg_psave_sel` is 0, and to sleep (code 11) if it is 1.
- R4: In standby the oscillator and bias enables are 1, and the analog enable, filter enable and ready are 0.
- R5: In sleep the oscillator, bias, analog and filter enables and ready are all 0. The code is 11.
- R6: A resume command (`cmd_valid`=1, `cmd_psr`=1, `cmd_cb`=0) taken in standby returns the block on the next clock to the active mode that `cfg_lp_sel` selects.
- R7: A resume command taken in sleep starts the wake state. During wake the code is 11, the oscillator and bias are enabled, the analog and filter enables are off, and ready is 0. The block stays there for exactly `WAKE_CYCLES` cycles. Ready rises on the following cycle, in the mode that `cfg_lp_sel` selects.
- R8: Every command is ignored during wake.
- R9: In a power-save state, any command other than resume is ignored, and `cfg_lp_sel` only selects the mode to return to. In an active mode, `cfg_psave_sel` has no effect until a save command arrives. A strobe that is not a save command has no effect.
- R10: The filter enable and the analog enable are 1 only in the normal and low power modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lp_sel | input | 1 | Low-power select (configuration bit 16) |
| cfg_psave_sel | input | 1 | Power-save select, 0 standby, 1 sleep (configuration bit 4) |
| cmd_valid | input | 1 | Command word strobe |
| cmd_cb | input | 1 | Command bit of the command word |
| cmd_psr | input | 1 | Power-save/resume bit of the command word |
| bias_en | output | 1 | Bias generator enable |
| osc_en | output | 1 | Oscillator enable |
| analog_en | output | 1 | Analog section enable |
| filt_en | output | 1 | Digital filter enable |
| mode_code | output | 2 | 00 normal, 01 low power, 10 standby, 11 sleep or wake |
| ready | output | 1 | Converter operational |

## Verification
The bench toggles the low-power select every cycle and then holds it for several cycles. This separates a one-clock follow from a latched or delayed one. Save commands are sent with each setting of the power-save select, interleaved with strobes that carry only one of the two control bits. This tells the standby and sleep paths apart and shows that a half command does not act. During the standby and sleep dwell the bench sends repeated save commands and resumes with the strobe low, and it changes the low-power select. This distinguishes a return target that tracks the select from commands that leak through. During the wake period the bench sends resume and save commands to confirm that the count can neither be cut short nor restarted.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL  = 3'd0,
        ST_LOWPWR  = 3'd1,
        ST_STANDBY = 3'd2,
        ST_SLEEP   = 3'd3,
        ST_WAKE    = 3'd4
    } pm_state_e;

    localparam int MODE_W = 2;

    localparam logic [MODE_W-1:0] CODE_NORMAL  = 2'b00;
    localparam logic [MODE_W-1:0] CODE_LOWPWR  = 2'b01;
    localparam logic [MODE_W-1:0] CODE_STANDBY = 2'b10;
    localparam logic [MODE_W-1:0] CODE_SLEEP   = 2'b11;

endpackage

// File: rtl/pwr_cmd_decode.sv
module pwr_cmd_decode (
    input  logic cmd_valid,
    input  logic cmd_cb,
    input  logic cmd_psr,
    output logic save_req,
    output logic resume_req
);

    // Save needs both control bits; resume is the save/resume bit alone.
    always_comb begin
        save_req   = cmd_valid & cmd_cb & cmd_psr;
        resume_req = cmd_valid & cmd_psr & ~cmd_cb;
    end

endmodule

// File: rtl/pwr_wake_timer.sv
module pwr_wake_timer #(
    parameter int WAKE_CYCLES = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int WAKE_W = (WAKE_CYCLES < 2) ? 1 : $clog2(WAKE_CYCLES + 1);
    localparam logic [WAKE_W-1:0] LAST = WAKE_W'(WAKE_CYCLES - 1);

    logic [WAKE_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && (cnt_q == LAST);

    // The count never runs past the last cycle of the start-up window.
    assert_wake_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // Leaving the wake window clears the count for the next one.
    assert_wake_cnt_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import pwr_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      lp_sel,
    input  logic      psave_sel,
    input  logic      save_req,
    input  logic      resume_req,
    input  logic      wake_done,
    output pm_state_e state_q
);

    pm_state_e state_d;
    pm_state_e active_st;
    logic      is_active;

    always_comb begin
        active_st = lp_sel ? ST_LOWPWR : ST_NORMAL;
        is_active = (state_q == ST_NORMAL) || (state_q == ST_LOWPWR);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NORMAL, ST_LOWPWR: begin
                if (save_req) state_d = psave_sel ? ST_SLEEP : ST_STANDBY;
                else          state_d = active_st;
            end
            ST_STANDBY: if (resume_req) state_d = active_st;
            ST_SLEEP:   if (resume_req) state_d = ST_WAKE;
            ST_WAKE:    if (wake_done)  state_d = active_st;
            default:    state_d = ST_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_NORMAL;
        else        state_q <= state_d;
    end

    assert_save_standby_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_active && save_req && !psave_sel) |=> state_q == ST_STANDBY);

    assert_save_sleep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_active && save_req && psave_sel) |=> state_q == ST_SLEEP);

    assert_standby_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STANDBY && resume_req) |=>
            (state_q == ST_NORMAL || state_q == ST_LOWPWR));

    assert_wake_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAKE && !wake_done) |=> state_q == ST_WAKE);

    assert_standby_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STANDBY && !resume_req) |=> state_q == ST_STANDBY);

    assert_sleep_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && !resume_req) |=> state_q == ST_SLEEP);

endmodule

// File: rtl/pwr_out_map.sv
module pwr_out_map
    import pwr_mode_pkg::*;
(
    input  pm_state_e         state_q,
    output logic              bias_en,
    output logic              osc_en,
    output logic              analog_en,
    output logic              filt_en,
    output logic [MODE_W-1:0] mode_code,
    output logic              ready
);

    always_comb begin
        bias_en   = 1'b0;
        osc_en    = 1'b0;
        analog_en = 1'b0;
        filt_en   = 1'b0;
        ready     = 1'b0;
        mode_code = CODE_SLEEP;
        unique case (state_q)
            ST_NORMAL, ST_LOWPWR: begin
                bias_en   = 1'b1;
                osc_en    = 1'b1;
                analog_en = 1'b1;
                filt_en   = 1'b1;
                ready     = 1'b1;
                mode_code = (state_q == ST_LOWPWR) ? CODE_LOWPWR : CODE_NORMAL;
            end
            ST_STANDBY: begin
                bias_en   = 1'b1;
                osc_en    = 1'b1;
                mode_code = CODE_STANDBY;
            end
            ST_SLEEP: mode_code = CODE_SLEEP;
            ST_WAKE: begin
                bias_en   = 1'b1;
                osc_en    = 1'b1;
                mode_code = CODE_SLEEP;
            end
            default: mode_code = CODE_SLEEP;
        endcase
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int WAKE_CYCLES = 2_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_lp_sel,
    input  logic       cfg_psave_sel,
    input  logic       cmd_valid,
    input  logic       cmd_cb,
    input  logic       cmd_psr,
    output logic       bias_en,
    output logic       osc_en,
    output logic       analog_en,
    output logic       filt_en,
    output logic [1:0] mode_code,
    output logic       ready
);

    pm_state_e state_q;
    logic      save_req;
    logic      resume_req;
    logic      wake_run;
    logic      wake_done;

    pwr_cmd_decode u_dec (
        .cmd_valid  (cmd_valid),
        .cmd_cb     (cmd_cb),
        .cmd_psr    (cmd_psr),
        .save_req   (save_req),
        .resume_req (resume_req)
    );

    assign wake_run = (state_q == ST_WAKE);

    pwr_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (wake_run),
        .done  (wake_done)
    );

    pwr_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .lp_sel     (cfg_lp_sel),
        .psave_sel  (cfg_psave_sel),
        .save_req   (save_req),
        .resume_req (resume_req),
        .wake_done  (wake_done),
        .state_q    (state_q)
    );

    pwr_out_map u_out (
        .state_q   (state_q),
        .bias_en   (bias_en),
        .osc_en    (osc_en),
        .analog_en (analog_en),
        .filt_en   (filt_en),
        .mode_code (mode_code),
        .ready     (ready)
    );

    // Operation becomes ready only by coming out of a save or wake state.
    assert_ready_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(mode_code) == CODE_SLEEP || $past(mode_code) == CODE_STANDBY));

    // Filter convolution stops whenever conversions are not possible.
    assert_filter_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
        filt_en |-> (ready && mode_code[1] == 1'b0));

    // A sleep code with the oscillator running is only the wake window.
    assert_wake_osc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == CODE_SLEEP && osc_en) |-> !ready);

endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WAKE = 12;

    localparam int M_N  = 0;
    localparam int M_LP = 1;
    localparam int M_SB = 2;
    localparam int M_SL = 3;
    localparam int M_WK = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_lp_sel = 1'b0;
    logic       cfg_psave_sel = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_cb = 1'b0;
    logic       cmd_psr = 1'b0;
    logic       bias_en, osc_en, analog_en, filt_en, ready;
    logic [1:0] mode_code;

    int    checks = 0;
    int    fails  = 0;
    int    m_state = M_N;
    int    m_wcnt  = 0;
    bit    cmp_on  = 1'b0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_mode_ctrl #(.WAKE_CYCLES(WAKE)) i_pwr_mode_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_lp_sel    (cfg_lp_sel),
        .cfg_psave_sel (cfg_psave_sel),
        .cmd_valid     (cmd_valid),
        .cmd_cb        (cmd_cb),
        .cmd_psr       (cmd_psr),
        .bias_en       (bias_en),
        .osc_en        (osc_en),
        .analog_en     (analog_en),
        .filt_en       (filt_en),
        .mode_code     (mode_code),
        .ready         (ready)
    );

    // Behavioural reference, written from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = M_N;
            m_wcnt  = 0;
        end else begin
            case (m_state)
                M_N, M_LP: begin
                    if (cmd_valid && cmd_cb && cmd_psr) m_state = cfg_psave_sel ? M_SL : M_SB;
                    else m_state = cfg_lp_sel ? M_LP : M_N;
                end
                M_SB: if (cmd_valid && cmd_psr && !cmd_cb) m_state = cfg_lp_sel ? M_LP : M_N;
                M_SL: if (cmd_valid && cmd_psr && !cmd_cb) begin
                    m_state = M_WK;
                    m_wcnt  = 0;
                end
                default: begin
                    if (m_wcnt == WAKE - 1) m_state = cfg_lp_sel ? M_LP : M_N;
                    else m_wcnt = m_wcnt + 1;
                end
            endcase
        end
    end

    // {bias, osc, analog, filt, code[1:0], ready}
    function automatic logic [6:0] expect_out(int st);
        case (st)
            M_N:     return 7'b1111_00_1;
            M_LP:    return 7'b1111_01_1;
            M_SB:    return 7'b1100_10_0;
            M_SL:    return 7'b0000_11_0;
            default: return 7'b1100_11_0;
        endcase
    endfunction

    task automatic check_now(string req);
        logic [6:0] act, exp;
        act = {bias_en, osc_en, analog_en, filt_en, mode_code, ready};
        exp = expect_out(m_state);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
        end
    endtask

    always @(negedge clk) if (cmp_on) check_now(cur_req);

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(logic cb, logic psr, logic v);
        @(negedge clk);
        cmd_valid = v; cmd_cb = cb; cmd_psr = psr;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_cb = 1'b0; cmd_psr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        idle(2);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        check_now("R1");
        cmp_on = 1'b1;
        idle(2);

        // R2: follow the low-power select, held and toggled
        cur_req = "R2";
        cfg_lp_sel = 1'b1; idle(3);
        cfg_lp_sel = 1'b0; idle(3);
        for (int i = 0; i < 6; i++) begin
            cfg_lp_sel = ~cfg_lp_sel; idle(1);
        end
        cfg_lp_sel = 1'b0;

        // R9: half commands and select changes while active do nothing
        cur_req = "R9";
        send(1'b1, 1'b0, 1'b1);
        send(1'b0, 1'b1, 1'b1);
        send(1'b1, 1'b1, 1'b0);
        cfg_psave_sel = 1'b1; idle(2);
        cfg_psave_sel = 1'b0; idle(2);

        // R3, R4: save into standby
        cur_req = "R4";
        send(1'b1, 1'b1, 1'b1);
        idle(4);
        // R9: ignored strobes and lp change in standby
        cur_req = "R9";
        send(1'b1, 1'b1, 1'b1);
        send(1'b1, 1'b0, 1'b1);
        send(1'b0, 1'b1, 1'b0);
        cfg_lp_sel = 1'b1; idle(3);
        // R6: resume to the selected mode
        cur_req = "R6";
        send(1'b0, 1'b1, 1'b1);
        idle(3);

        // R3, R5: save into sleep from low power
        cur_req = "R5";
        cfg_psave_sel = 1'b1;
        send(1'b1, 1'b1, 1'b1);
        idle(4);
        cur_req = "R9";
        send(1'b1, 1'b1, 1'b1);
        cfg_psave_sel = 1'b0;
        cfg_lp_sel = 1'b0; idle(3);
        // R7: resume from sleep through the wake count
        cur_req = "R7";
        send(1'b0, 1'b1, 1'b1);
        // R8: commands during wake are ignored
        cur_req = "R8";
        send(1'b0, 1'b1, 1'b1);
        send(1'b1, 1'b1, 1'b1);
        cur_req = "R7";
        idle(WAKE + 4);

        // R3, R10: standby again from normal, resume into low power
        cur_req = "R10";
        send(1'b1, 1'b1, 1'b1);
        idle(2);
        cfg_lp_sel = 1'b1;
        send(1'b0, 1'b1, 1'b1);
        idle(2);
        // sleep from low power and wake into low power
        cur_req = "R7";
        cfg_psave_sel = 1'b1;
        send(1'b1, 1'b1, 1'b1);
        idle(2);
        send(1'b0, 1'b1, 1'b1);
        idle(WAKE + 3);

        cmp_on = 1'b0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule